// File: doc/BRIEF.md
# Indirect Data Addressing Unit

This block resolves every data-memory access of a small 8-bit core into a 9-bit RAM address. A normal access takes its address from the instruction: a 7-bit file offset combined with a 2-bit bank number. One offset, zero in every bank, has no storage behind it. An access to that offset is redirected through the pointer register. The pointer is supplied by the core as an 8-bit value, and a separate indirect-bank bit is placed above it to form the address.

When the redirected address lands back on the virtual offset, in either indirect bank, the access goes nowhere. A read returns 0x00 and a write changes no memory. The core may still update its own flags, but that logic lies outside this block. Software can step the pointer through consecutive locations to sweep a range of RAM.

A synchronous-write, combinational-read RAM model sits under the unit so that the whole path can be checked.

Top module: `ind_addr_unit`

## Requirements
- R1: After reset is released, a read of any location other than offset 0 returns 0x00.
- R2: When the file offset is not 0, the effective address is {bank_i[1:0], dir_addr_i[6:0]}.
- R3: When the file offset is 0, the effective address is {ibank_i, fsr_i[7:0]}.
- R4: A redirected read whose target is not the virtual offset returns the RAM byte at {ibank_i, fsr_i}. This is the same byte a direct access to that address sees.
- R5: A redirected write whose target is not the virtual offset stores wdata_i at {ibank_i, fsr_i} on the next rising clock edge.
- R6: A redirected read whose target has fsr_i[6:0] == 0 returns 0x00, for both values of ibank_i and both values of fsr_i[7].
- R7: A redirected write whose target has fsr_i[6:0] == 0 keeps ram_we_o low and leaves every RAM location unchanged.
- R8: ram_we_o is high only while req_i and we_i are both high. rdata_o is 0x00 while req_i is low. A write request with req_i low changes no memory.
- R9: Reads are combinational. During the cycle that carries a write, the read path still shows the old byte. From the cycle after that edge it shows the new byte.
- R10: Redirected writes with fsr_i incremented by one between accesses fill consecutive RAM locations, and each lands only at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the RAM |
| dir_addr_i | input | 7 | File offset from the instruction |
| bank_i | input | 2 | Bank number for normal accesses |
| ibank_i | input | 1 | Bank bit for redirected accesses |
| fsr_i | input | 8 | Pointer value |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| wdata_i | input | 8 | Write data |
| eff_addr_o | output | 9 | Resolved RAM address |
| rdata_o | output | 8 | Read data returned to the core |
| ram_we_o | output | 1 | RAM write enable |

## Verification
The address, the read data and the write enable are combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples them one nanosecond later. A write becomes visible only after the following rising edge. Each write check therefore samples once before that edge, to see the old byte, and once in the next low phase, to see the new byte. Every write the bench issues is mirrored in a 512-entry model, and that model is swept against the RAM after the suppressed-write and pointer-walk cases.

// File: rtl/ind_addr_pkg.sv
package ind_addr_pkg;
  parameter int unsigned DIR_W  = 7;
  parameter int unsigned BANK_W = 2;
  parameter int unsigned PTR_W  = 8;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned IND_OFS = 0;

  localparam int unsigned ADDR_W = BANK_W + DIR_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    addr_t addr;
    logic  indirect;
    logic  null_tgt;
  } resolve_t;
endpackage

// File: rtl/ind_addr_resolve.sv
module ind_addr_resolve
  import ind_addr_pkg::*;
#(
  parameter int unsigned D_W = DIR_W,
  parameter int unsigned B_W = BANK_W,
  parameter int unsigned P_W = PTR_W,
  parameter int unsigned OFS = IND_OFS
) (
  input  logic [D_W-1:0] dir_addr_i,
  input  logic [B_W-1:0] bank_i,
  input  logic           ibank_i,
  input  logic [P_W-1:0] fsr_i,
  output resolve_t       res_o
);
  localparam int unsigned A_W = B_W + D_W;
  localparam logic [D_W-1:0] OFS_V = D_W'(OFS);

  logic           is_ind;
  logic [A_W-1:0] dir_full;
  logic [A_W-1:0] ind_full;

  assign is_ind   = (dir_addr_i == OFS_V);
  assign dir_full = {bank_i, dir_addr_i};
  assign ind_full = A_W'({ibank_i, fsr_i});

  always_comb begin
    res_o.indirect = is_ind;
    res_o.addr     = is_ind ? ind_full : dir_full;
    // pointer aimed back at the virtual offset in any bank
    res_o.null_tgt = is_ind && (fsr_i[D_W-1:0] == OFS_V);
  end
endmodule

// File: rtl/ind_access_ctrl.sv
module ind_access_ctrl
  import ind_addr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  resolve_t res_i,
  input  logic     req_i,
  input  logic     we_i,
  input  data_t    ram_rdata_i,
  output logic     ram_we_o,
  output data_t    rdata_o
);
  assign ram_we_o = req_i && we_i && !res_i.null_tgt;
  assign rdata_o  = (req_i && !res_i.null_tgt) ? ram_rdata_i : '0;

  assert_null_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_i.null_tgt |-> !ram_we_o);
  assert_null_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && res_i.null_tgt) |-> (rdata_o == '0));
  assert_we_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |-> !ram_we_o);
endmodule

// File: rtl/ind_data_ram.sv
module ind_data_ram
  import ind_addr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  addr_t addr_i,
  input  logic  we_i,
  input  data_t wdata_i,
  output data_t rdata_o
);
  data_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/ind_addr_unit.sv
module ind_addr_unit
  import ind_addr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIR_W-1:0]    dir_addr_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic                ibank_i,
  input  logic [PTR_W-1:0]    fsr_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [ADDR_W-1:0]   eff_addr_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                ram_we_o
);
  resolve_t res;
  data_t    ram_rdata;

  ind_addr_resolve u_resolve (
    .dir_addr_i (dir_addr_i),
    .bank_i     (bank_i),
    .ibank_i    (ibank_i),
    .fsr_i      (fsr_i),
    .res_o      (res)
  );

  ind_access_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_i       (res),
    .req_i       (req_i),
    .we_i        (we_i),
    .ram_rdata_i (ram_rdata),
    .ram_we_o    (ram_we_o),
    .rdata_o     (rdata_o)
  );

  ind_data_ram u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (res.addr),
    .we_i    (ram_we_o),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  assign eff_addr_o = res.addr;

  assert_ind_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_addr_i == DIR_W'(IND_OFS)) |-> (eff_addr_o == ADDR_W'({ibank_i, fsr_i})));
  assert_dir_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_addr_i != DIR_W'(IND_OFS)) |-> (eff_addr_o == {bank_i, dir_addr_i}));
  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0));
endmodule

// File: tb/ind_addr_unit_bench.sv
`timescale 1ns/1ps
module ind_addr_unit_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] dir_addr = 0;
  logic [1:0] bank = 0;
  logic       ibank = 0;
  logic [7:0] fsr = 0;
  logic       req = 0;
  logic       we = 0;
  logic [7:0] wdata = 0;
  logic [8:0] eff_addr;
  logic [7:0] rdata;
  logic       ram_we;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [512];
  bit done = 0;

  always #2 clk = ~clk;

  ind_addr_unit u_ind_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .dir_addr_i(dir_addr), .bank_i(bank),
    .ibank_i(ibank), .fsr_i(fsr), .req_i(req), .we_i(we), .wdata_i(wdata),
    .eff_addr_o(eff_addr), .rdata_o(rdata), .ram_we_o(ram_we)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] d, input logic [1:0] b, input logic ib,
                       input logic [7:0] f, input logic r, input logic w, input logic [7:0] wd);
    @(negedge clk);
    dir_addr = d; bank = b; ibank = ib; fsr = f; req = r; we = w; wdata = wd;
    #1;
  endtask

  task automatic idle();
    drive(7'h01, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  // direct read of a 9-bit address (offset must be non-zero)
  task automatic dread(input logic [8:0] a, input string tag);
    drive(a[6:0], a[8:7], 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    chk(tag, rdata, model[a]);
  endtask

  task automatic sweep(input string tag);
    int bad = 0;
    for (int a = 0; a < 512; a++) begin
      if (a[6:0] == 0) continue;
      drive(a[6:0], a[8:7], 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
      if (rdata !== model[a]) begin
        bad++;
        if (bad < 4) $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, model[a]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic t_reset();
    for (int a = 1; a < 512; a += 37) if (a[6:0] != 0) dread(9'(a), "R1");
  endtask

  task automatic t_direct();
    drive(7'h25, 2'd2, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA5);
    chk("R2 addr", eff_addr, 9'h125);
    chk("R9 old", rdata, 8'h00);
    chk("R8 we", ram_we, 1);
    model[9'h125] = 8'hA5;
    idle();
    dread(9'h125, "R9 new");
    drive(7'h7F, 2'd3, 1'b1, 8'h12, 1'b0, 1'b0, 8'h00);
    chk("R2 addr top", eff_addr, 9'h1FF);
  endtask

  task automatic t_indirect();
    drive(7'h00, 2'd0, 1'b1, 8'h25, 1'b1, 1'b0, 8'h00);
    chk("R3 addr", eff_addr, 9'h125);
    chk("R4 read", rdata, 8'hA5);
    drive(7'h00, 2'd3, 1'b0, 8'h33, 1'b1, 1'b1, 8'h5C);
    chk("R3 addr ib0", eff_addr, 9'h033);
    chk("R8 we ind", ram_we, 1);
    model[9'h033] = 8'h5C;
    idle();
    dread(9'h033, "R5");
  endtask

  task automatic t_null();
    for (int k = 0; k < 4; k++) begin
      logic ib = k[0];
      logic [7:0] f = k[1] ? 8'h80 : 8'h00;
      drive(7'h00, 2'd1, ib, f, 1'b1, 1'b0, 8'h00);
      chk("R6", rdata, 0);
      drive(7'h00, 2'd1, ib, f, 1'b1, 1'b1, 8'hEE);
      chk("R7 we", ram_we, 0);
    end
    idle();
    sweep("R7 mem");
  endtask

  task automatic t_gate();
    drive(7'h40, 2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h77);
    chk("R8 we noreq", ram_we, 0);
    chk("R8 rdata noreq", rdata, 0);
    drive(7'h40, 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h77);
    chk("R8 we read", ram_we, 0);
    idle();
    dread(9'h0C0, "R8 unchanged");
  endtask

  task automatic t_walk();
    for (int i = 0; i < 16; i++) begin
      drive(7'h00, 2'd0, 1'b1, 8'(8'hF8 + i), 1'b1, 1'b1, 8'(8'h90 + i));
      if (8'(8'hF8 + i) & 8'h7F) model[{1'b1, 8'(8'hF8 + i)}] = 8'(8'h90 + i);
    end
    for (int i = 0; i < 16; i++) begin
      drive(7'h00, 2'd0, 1'b0, 8'(8'h20 + i), 1'b1, 1'b1, 8'(8'h10 + i));
      model[9'(8'h20 + i)] = 8'(8'h10 + i);
    end
    idle();
    dread(9'h02F, "R10 last");
    dread(9'h1FF, "R10 top");
    sweep("R10 mem");
  endtask

  initial begin
    for (int a = 0; a < 512; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direct();
    t_indirect();
    t_null();
    t_gate();
    t_walk();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule